// File: doc/BRIEF.md
# Counter-Compare Pulse Output Generator

This block turns the value of a shared delay counter into a set of independent pulse outputs. Every channel carries a pair of 16-bit match values, a rise point and a fall point, packed into a single 32-bit word. The channel output is set on the cycle after the counter equals the rise point. It is cleared on the cycle after the counter equals the fall point. Between matches the output keeps its value. When the fall point is below the rise point, the pulse spans the counter wrap.

Match values are written into a shadow copy and do nothing until the owning core raises its load strobe. At that point all shadow words move into the active compare registers together. The per-channel enable mask is not buffered, so a mask write takes effect at once. The counter itself, its prescaler and whatever consumes the pulses live outside this block. The block sees the count, a running indication, a module enable and the load strobe as inputs.

Top module: `pulse_out_gen`

## Requirements
- R1: After reset every output is low, and every shadow word, every active word and the enable mask are zero.
- R2: With the channel enabled, the counter running and the module enabled, the output is high in the cycle after the count equals the rise value, which sits in bits [31:16] of the channel word.
- R3: Under the same conditions, the output is low in the cycle after the count equals the fall value, which sits in bits [15:0]. When neither value matches, the output keeps its previous level.
- R4: A channel whose active rise and fall values are equal keeps its output low.
- R5: A write to a channel word changes only its shadow copy. The active compare values change only on a cycle with the load strobe high, and then every channel's shadow copy is copied in at once.
- R6: When a write and the load strobe fall in the same cycle, the active copy takes the shadow content from before that write, and the written word stays in the shadow.
- R7: Mask bit i enables channel i. A disabled channel drives low. A mask write affects the compare at the next clock edge without waiting for the load strobe.
- R8: When the counter is not running or the module is disabled, all outputs are low in the next cycle. After operation resumes, an output stays low until its next rise match.
- R9: A channel whose fall value is below its rise value produces a pulse that stays high across the counter wrap and falls at the fall value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low forces all outputs low |
| cnt_run | input | 1 | High while the shared counter is counting |
| count | input | 16 | Current value of the shared counter |
| load_stb | input | 1 | Load event: copies all shadow words into the active registers |
| dly_wr | input | 1 | Write strobe for a channel's packed rise/fall word |
| dly_sel | input | $clog2(NCH) | Channel index for the write |
| dly_wdata | input | 32 | Packed word: rise in [31:16], fall in [15:0] |
| mask_wr | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | NCH | New enable mask, one bit per channel |
| pulse_out | output | NCH | Registered pulse outputs, one per channel |

## Verification
Two pairs of events can land in the same cycle. The first is a channel-word write together with the load strobe. The bench provokes it by staging a first word in the shadow, then writing a second word in the very cycle the load strobe is high. It then judges the outcome at the output: a count equal to the first word's rise point must raise the pulse, and a count equal to the second word's rise point must leave the pulse unchanged until a later load. The second pair is a load coinciding with a live compare. It is judged by confirming that the compare in the load cycle still follows the old active values and the new values govern only from the next edge.

// File: rtl/pog_pkg.sv
package pog_pkg;

    parameter int POG_CNT_W = 16;

    typedef logic [POG_CNT_W-1:0] pog_cnt_t;

    // rise point in the upper half, fall point in the lower half
    typedef struct packed {
        pog_cnt_t rise;
        pog_cnt_t fall;
    } pog_pair_t;

    localparam int POG_WORD_W = $bits(pog_pair_t);

endpackage

// File: rtl/pog_mask_reg.sv
module pog_mask_reg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [NCH-1:0] wdata_i,
    output logic [NCH-1:0] mask_o
);

    typedef struct packed {
        logic [NCH-1:0] mask;
    } mask_st_t;

    mask_st_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_i) begin
            m_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign mask_o = m_q.mask;

    // R7: a mask write is visible from the next edge, unbuffered
    a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i)));

    a_r7_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

endmodule

// File: rtl/pog_dly_bank.sv
module pog_dly_bank
    import pog_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  pog_pair_t             wdata_i,
    input  logic                  load_i,
    output pog_pair_t [NCH-1:0]   act_o
);

    typedef struct packed {
        pog_pair_t [NCH-1:0] shd;
        pog_pair_t [NCH-1:0] act;
    } bank_st_t;

    bank_st_t b_d, b_q;

    logic sel_ok;
    assign sel_ok = (32'(sel_i) < NCH);

    always_comb begin
        b_d = b_q;
        // load copies the shadow as it stood before any same-cycle write
        if (load_i) begin
            for (int i = 0; i < NCH; i++) begin
                b_d.act[i] = b_q.shd[i];
            end
        end
        if (wr_i && sel_ok) begin
            b_d.shd[sel_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign act_o = b_q.act;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R5: active values move only on a load
        a_r5_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !load_i |=> $stable(b_q.act[g]));

        // R6: the load takes the pre-write shadow content
        a_r6_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> (b_q.act[g] == $past(b_q.shd[g])));
    end

endmodule

// File: rtl/pog_chan.sv
module pog_chan
    import pog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gate_i,
    input  logic      en_i,
    input  pog_cnt_t  count_i,
    input  pog_pair_t dly_i,
    output logic      out_o
);

    typedef struct packed {
        logic lvl;
    } chan_st_t;

    chan_st_t c_d, c_q;

    logic hit_rise, hit_fall, degenerate;

    assign degenerate = (dly_i.rise == dly_i.fall);
    assign hit_rise   = (count_i == dly_i.rise);
    assign hit_fall   = (count_i == dly_i.fall);

    always_comb begin
        c_d = c_q;
        if (!gate_i || !en_i || degenerate) begin
            c_d.lvl = 1'b0;
        end else if (hit_rise) begin
            c_d.lvl = 1'b1;
        end else if (hit_fall) begin
            c_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_o = c_q.lvl;

    a_r8_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |=> !out_o);

    a_r7_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !out_o);

    a_r4_equal_low: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_i.rise == dly_i.fall) |=> !out_o);

    a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && en_i && (dly_i.rise != dly_i.fall) && (count_i == dly_i.rise))
        |=> out_o);

    a_r3_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && en_i && (dly_i.rise != dly_i.fall) && (count_i == dly_i.fall))
        |=> !out_o);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && en_i && (count_i != dly_i.rise) && (count_i != dly_i.fall))
        |=> (out_o == $past(out_o)));

endmodule

// File: rtl/pulse_out_gen.sv
module pulse_out_gen
    import pog_pkg::*;
#(
    parameter int NCH   = 4,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CNT_W = POG_CNT_W,
    localparam int WRD_W = POG_WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             cnt_run,
    input  logic [CNT_W-1:0] count,
    input  logic             load_stb,
    input  logic             dly_wr,
    input  logic [SEL_W-1:0] dly_sel,
    input  logic [WRD_W-1:0] dly_wdata,
    input  logic             mask_wr,
    input  logic [NCH-1:0]   mask_wdata,
    output logic [NCH-1:0]   pulse_out
);

    pog_pair_t [NCH-1:0] act_w;
    logic      [NCH-1:0] mask_w;
    logic                gate_w;

    assign gate_w = mod_en & cnt_run;

    pog_dly_bank #(
        .NCH   (NCH),
        .SEL_W (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (dly_wr),
        .sel_i   (dly_sel),
        .wdata_i (pog_pair_t'(dly_wdata)),
        .load_i  (load_stb),
        .act_o   (act_w)
    );

    pog_mask_reg #(
        .NCH (NCH)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (mask_wdata),
        .mask_o  (mask_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pog_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_i  (gate_w),
            .en_i    (mask_w[g]),
            .count_i (count),
            .dly_i   (act_w[g]),
            .out_o   (pulse_out[g])
        );
    end

    // R8: a stopped counter or disabled module clears every output
    a_r8_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_en && cnt_run) |=> (pulse_out == '0));

endmodule

// File: tb/pulse_out_gen_tb_top.sv
module pulse_out_gen_tb_top;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mod_en = 1'b0;
    logic           cnt_run = 1'b0;
    logic [15:0]    count = '0;
    logic           load_stb = 1'b0;
    logic           dly_wr = 1'b0;
    logic [1:0]     dly_sel = '0;
    logic [31:0]    dly_wdata = '0;
    logic           mask_wr = 1'b0;
    logic [NCH-1:0] mask_wdata = '0;
    logic [NCH-1:0] pulse_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4ns clk = ~clk;

    pulse_out_gen #(.NCH(NCH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_en     (mod_en),
        .cnt_run    (cnt_run),
        .count      (count),
        .load_stb   (load_stb),
        .dly_wr     (dly_wr),
        .dly_sel    (dly_sel),
        .dly_wdata  (dly_wdata),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .pulse_out  (pulse_out)
    );

    typedef struct packed {
        logic [15:0] cnt;
        logic        run;
        logic        en;
        logic [3:0]  exp;
        logic [3:0]  req;
    } vec_t;

    // Active words: ch0 (5,9), ch1 (9,3), ch2 (7,7), ch3 (2,4) masked off
    localparam vec_t TBL [16] = '{
        '{16'd0,  1'b1, 1'b1, 4'b0000, 4'd3},  // R3 hold low
        '{16'd3,  1'b1, 1'b1, 4'b0000, 4'd3},  // R3 fall on already-low
        '{16'd5,  1'b1, 1'b1, 4'b0001, 4'd2},  // R2 ch0 rise
        '{16'd6,  1'b1, 1'b1, 4'b0001, 4'd3},  // R3 hold high
        '{16'd9,  1'b1, 1'b1, 4'b0010, 4'd9},  // R9 ch0 fall, ch1 rise
        '{16'd10, 1'b1, 1'b1, 4'b0010, 4'd9},  // R9 ch1 held
        '{16'd2,  1'b1, 1'b1, 4'b0010, 4'd9},  // R9 held across wrap
        '{16'd3,  1'b1, 1'b1, 4'b0000, 4'd9},  // R9 ch1 fall after wrap
        '{16'd5,  1'b1, 1'b1, 4'b0001, 4'd2},  // R2
        '{16'd7,  1'b1, 1'b1, 4'b0001, 4'd4},  // R4 ch2 equal stays low
        '{16'd8,  1'b0, 1'b1, 4'b0000, 4'd8},  // R8 counter stopped
        '{16'd8,  1'b1, 1'b1, 4'b0000, 4'd8},  // R8 stays low on resume
        '{16'd5,  1'b1, 1'b1, 4'b0001, 4'd8},  // R8 next rise
        '{16'd6,  1'b1, 1'b0, 4'b0000, 4'd8},  // R8 module disabled
        '{16'd6,  1'b1, 1'b1, 4'b0000, 4'd8},  // R8 low until rise
        '{16'd9,  1'b1, 1'b1, 4'b0010, 4'd7}   // R7 ch3 masked, ch1 rises
    };

    task automatic check(input string req, input logic [NCH-1:0] got,
                         input logic [NCH-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: pulse_out=%b expected=%b", req, got, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic apply(input logic [15:0] c, input logic r, input logic e);
        count   = c;
        cnt_run = r;
        mod_en  = e;
        @(negedge clk);
    endtask

    task automatic wr_word(input int ch, input logic [15:0] rise,
                           input logic [15:0] fall, input logic with_load);
        dly_wr    = 1'b1;
        dly_sel   = ch[1:0];
        dly_wdata = {rise, fall};
        load_stb  = with_load;
        @(negedge clk);
        dly_wr    = 1'b0;
        load_stb  = 1'b0;
    endtask

    task automatic do_load();
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic wr_mask(input logic [NCH-1:0] m);
        mask_wr    = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_wr    = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", pulse_out, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset mask is zero and active words are zero
        apply(16'd0, 1'b1, 1'b1);
        check("R1", pulse_out, 4'b0000);

        wr_word(0, 16'd5, 16'd9, 1'b0);
        wr_word(1, 16'd9, 16'd3, 1'b0);
        wr_word(2, 16'd7, 16'd7, 1'b0);
        wr_word(3, 16'd2, 16'd4, 1'b0);
        wr_mask(4'b0111);
        // R5: shadow only, rise point 5 must not fire yet
        apply(16'd5, 1'b1, 1'b1);
        apply(16'd6, 1'b1, 1'b1);
        check("R5", pulse_out, 4'b0000);
        do_load();

        for (int i = 0; i < 16; i++) begin
            apply(TBL[i].cnt, TBL[i].run, TBL[i].en);
            check($sformatf("R%0d", TBL[i].req), pulse_out, TBL[i].exp);
        end

        // R7: enabling ch3 takes effect without a load
        wr_mask(4'b1111);
        apply(16'd2, 1'b1, 1'b1);
        check("R7", pulse_out, 4'b1010);
        wr_mask(4'b1101);
        apply(16'd6, 1'b1, 1'b1);
        check("R7", pulse_out, 4'b1000);

        // R5: staged word (11,12) not used before a load
        wr_word(0, 16'd11, 16'd12, 1'b0);
        apply(16'd11, 1'b1, 1'b1);
        check("R5", pulse_out, 4'b1000);
        // R6: write (1,2) in the load cycle; active must become (11,12)
        wr_word(0, 16'd1, 16'd2, 1'b1);
        apply(16'd11, 1'b1, 1'b1);
        check("R6", pulse_out, 4'b1001);
        apply(16'd1, 1'b1, 1'b1);
        check("R6", pulse_out, 4'b1001);
        // R5: a load alone promotes (1,2); compare in the load cycle uses old values
        do_load();
        check("R5", pulse_out, 4'b1001);
        apply(16'd2, 1'b1, 1'b1);
        check("R5", pulse_out, 4'b1000);
        apply(16'd1, 1'b1, 1'b1);
        check("R2", pulse_out, 4'b1001);

        // R1: reset in mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", pulse_out, 4'b0000);
        rst_n = 1'b1;
        apply(16'd2, 1'b1, 1'b1);
        check("R1", pulse_out, 4'b0000);

        finish_run();
    end

endmodule